// File: doc/BRIEF.md
# Policy-Selectable Data Cache Controller

A direct-mapped data cache controller. It sits between a processor load/store port and a slower next-level memory. Each line holds a valid bit, a dirty bit, a tag and a full 64-byte block of eight 64-bit words. Two configuration inputs pick the policies. One chooses how a store that hits is handled: the copy in the cache only, or the cache and the next level together. The other chooses whether a store that misses brings the block into the cache first or goes straight past it. The usual pairing is copy-back with fill-on-store-miss. Store-through with store-around also works, and so do the two mixed pairings.

The controller looks up the tag on a processor request and serves hits in one cycle. It runs a small state machine for everything that needs memory: the write-back of a dirty victim, the block refill, and single-word stores. Memory uses a request/acknowledge handshake. A whole block moves in one transaction for refills and write-backs, and one word moves for a store-through or store-around write. While a memory transaction is outstanding the processor sees a busy signal. The policy inputs may change only while the controller is idle.

Top module: `dcache_policy_ctrl`

## Requirements
- R1: After reset every line is invalid and clean, `cpu_busy` and `mem_req` are low, and the first access to any address misses.
- R2: A read hit returns the stored word on `cpu_rdata` with `cpu_ack` high in the cycle after the request is accepted, and causes no memory transaction.
- R3: With `cfg_write_back`=1, a store hit updates the cached word, marks the line dirty, acknowledges in the next cycle and causes no memory transaction.
- R4: With `cfg_write_back`=0, a store hit updates the cached word and issues one word write (`mem_we`=1, `mem_block`=0) of the store data. The store is acknowledged in the cycle after that write's `mem_ack`.
- R5: With `cfg_write_alloc`=1, a store miss first refills the block and then completes the store under the selected store-hit policy.
- R6: With `cfg_write_alloc`=0, a store miss issues one word write to memory and leaves every line unchanged, so a later read of that address still misses.
- R7: A miss that replaces a valid dirty line first writes the whole victim block (`mem_we`=1, `mem_block`=1) to the victim's line base address. The refill request is issued only after that write is acknowledged.
- R8: A miss that replaces an invalid or clean line issues no write-back. A refilled line is clean unless a copy-back store then modifies it.
- R9: A read miss returns the requested word of the newly filled block.
- R10: `cpu_busy` is high while any memory transaction is outstanding. `mem_req`, `mem_we`, `mem_block` and `mem_addr` hold steady until `mem_ack`.
- R11: Byte address split: bits [2:0] are ignored, [5:3] select the word, [7:6] select the set, and [15:8] form the tag. Block transfers use the line base address (low six bits zero), and word transfers use the word address (low three bits zero).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_write_back | input | 1 | 1: copy-back store hits, 0: store-through |
| cfg_write_alloc | input | 1 | 1: refill on store miss, 0: store-around |
| cpu_req | input | 1 | Processor request, accepted when `cpu_busy` is low |
| cpu_we | input | 1 | 1: store, 0: load |
| cpu_addr | input | ADDR_W | Byte address |
| cpu_wdata | input | WORD_W | Store data |
| cpu_rdata | output | WORD_W | Load data, valid with `cpu_ack` |
| cpu_ack | output | 1 | One-cycle completion pulse |
| cpu_busy | output | 1 | Controller not idle; requests are not taken |
| mem_req | output | 1 | Memory request, held until `mem_ack` |
| mem_we | output | 1 | 1: write, 0: block read |
| mem_block | output | 1 | 1: whole-block transfer, 0: single word |
| mem_addr | output | ADDR_W | Line base or word address |
| mem_wword | output | WORD_W | Word write data |
| mem_wline | output | WORD_W*LINE_WORDS | Victim block data |
| mem_rline | input | WORD_W*LINE_WORDS | Refill block data, valid with `mem_ack` |
| mem_ack | input | 1 | Memory completion, one cycle |

## Verification
A hit that needs no memory traffic is acknowledged in the first cycle after the accepting clock edge. Every other access is acknowledged one cycle after the final `mem_ack` of its sequence, and the transaction counts tell which sequence ran. The bench drives a request, counts cycles at falling edges from the accepting edge, and checks latency, load data, transaction kinds and addresses only once `cpu_ack` is seen. The memory model acknowledges each request two falling edges after it appears, so every memory result is settled before the acknowledgement reaches the processor side.

// File: rtl/dc_pkg.sv
package dc_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_EVICT = 2'd1,
    ST_FILL  = 2'd2,
    ST_WORD  = 2'd3
  } dc_state_e;
endpackage

// File: rtl/dc_line_store.sv
module dc_line_store #(
  parameter int SETS   = 4,
  parameter int TAG_W  = 8,
  parameter int LINE_W = 512,
  localparam int IDX_W = $clog2(SETS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic              rd_valid,
  output logic              rd_dirty,
  output logic [TAG_W-1:0]  rd_tag,
  output logic [LINE_W-1:0] rd_line,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [TAG_W-1:0]  wr_tag,
  input  logic [LINE_W-1:0] wr_line,
  input  logic              wr_dirty
);
  logic [SETS-1:0]   valid_q;
  logic [SETS-1:0]   dirty_q;
  logic [TAG_W-1:0]  tag_q  [SETS];
  logic [LINE_W-1:0] data_q [SETS];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= '0;
      dirty_q <= '0;
    end else if (wr_en) begin
      valid_q[wr_idx] <= 1'b1;
      dirty_q[wr_idx] <= wr_dirty;
    end
  end

  always_ff @(posedge clk) begin
    if (wr_en) begin
      tag_q[wr_idx]  <= wr_tag;
      data_q[wr_idx] <= wr_line;
    end
  end

  assign rd_valid = valid_q[rd_idx];
  assign rd_dirty = dirty_q[rd_idx];
  assign rd_tag   = tag_q[rd_idx];
  assign rd_line  = data_q[rd_idx];
endmodule

// File: rtl/dc_mem_port.sv
module dc_mem_port
  import dc_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int WORD_W = 64,
  parameter int LINE_W = 512
) (
  input  dc_state_e         state,
  input  logic [ADDR_W-1:0] victim_base,
  input  logic [ADDR_W-1:0] fill_base,
  input  logic [ADDR_W-1:0] word_addr,
  input  logic [LINE_W-1:0] victim_line,
  input  logic [WORD_W-1:0] word_data,
  output logic              mem_req,
  output logic              mem_we,
  output logic              mem_block,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [LINE_W-1:0] mem_wline,
  output logic [WORD_W-1:0] mem_wword
);
  always_comb begin
    mem_req   = 1'b0;
    mem_we    = 1'b0;
    mem_block = 1'b0;
    mem_addr  = '0;
    mem_wline = '0;
    mem_wword = '0;
    unique case (state)
      ST_EVICT: begin
        mem_req   = 1'b1;
        mem_we    = 1'b1;
        mem_block = 1'b1;
        mem_addr  = victim_base;
        mem_wline = victim_line;
      end
      ST_FILL: begin
        mem_req   = 1'b1;
        mem_block = 1'b1;
        mem_addr  = fill_base;
      end
      ST_WORD: begin
        mem_req   = 1'b1;
        mem_we    = 1'b1;
        mem_addr  = word_addr;
        mem_wword = word_data;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/dcache_policy_ctrl.sv
module dcache_policy_ctrl
  import dc_pkg::*;
#(
  parameter int ADDR_W     = 16,
  parameter int WORD_W     = 64,
  parameter int LINE_WORDS = 8,
  parameter int SETS       = 4,
  localparam int LINE_W    = WORD_W * LINE_WORDS
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_write_back,
  input  logic              cfg_write_alloc,
  input  logic              cpu_req,
  input  logic              cpu_we,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic [WORD_W-1:0] cpu_wdata,
  output logic [WORD_W-1:0] cpu_rdata,
  output logic              cpu_ack,
  output logic              cpu_busy,
  output logic              mem_req,
  output logic              mem_we,
  output logic              mem_block,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [WORD_W-1:0] mem_wword,
  output logic [LINE_W-1:0] mem_wline,
  input  logic [LINE_W-1:0] mem_rline,
  input  logic              mem_ack
);
  localparam int BOFF_W = $clog2(WORD_W / 8);
  localparam int WSEL_W = $clog2(LINE_WORDS);
  localparam int IDX_W  = $clog2(SETS);
  localparam int LOFF_W = BOFF_W + WSEL_W;
  localparam int TAG_W  = ADDR_W - LOFF_W - IDX_W;

  // ---- address arithmetic (R11)
  function automatic logic [IDX_W-1:0] f_idx(input logic [ADDR_W-1:0] a);
    return a[LOFF_W +: IDX_W];
  endfunction
  function automatic logic [TAG_W-1:0] f_tag(input logic [ADDR_W-1:0] a);
    return a[ADDR_W-1 -: TAG_W];
  endfunction
  function automatic logic [WSEL_W-1:0] f_wsel(input logic [ADDR_W-1:0] a);
    return a[BOFF_W +: WSEL_W];
  endfunction
  function automatic logic [ADDR_W-1:0] f_base(input logic [TAG_W-1:0] t,
                                               input logic [IDX_W-1:0] i);
    return {t, i, {LOFF_W{1'b0}}};
  endfunction
  function automatic logic [ADDR_W-1:0] f_waddr(input logic [ADDR_W-1:0] a);
    return {a[ADDR_W-1:BOFF_W], {BOFF_W{1'b0}}};
  endfunction
  function automatic logic [LINE_W-1:0] f_merge(input logic [LINE_W-1:0] l,
                                                input logic [WSEL_W-1:0] s,
                                                input logic [WORD_W-1:0] d);
    logic [LINE_W-1:0] r;
    r = l;
    r[s*WORD_W +: WORD_W] = d;
    return r;
  endfunction
  function automatic logic [WORD_W-1:0] f_pick(input logic [LINE_W-1:0] l,
                                               input logic [WSEL_W-1:0] s);
    return l[s*WORD_W +: WORD_W];
  endfunction

  dc_state_e         state_q, state_d;
  logic              rq_we;
  logic [ADDR_W-1:0] rq_addr;
  logic [WORD_W-1:0] rq_wdata;
  logic              ack_q;
  logic [WORD_W-1:0] rdata_q;

  // line store signals
  logic              rd_valid, rd_dirty;
  logic [TAG_W-1:0]  rd_tag;
  logic [LINE_W-1:0] rd_line;
  logic              wr_en, wr_dirty;
  logic [IDX_W-1:0]  wr_idx;
  logic [TAG_W-1:0]  wr_tag;
  logic [LINE_W-1:0] wr_line;

  // ---- named internal events
  logic [ADDR_W-1:0] look_addr;
  logic              lookup_hit, victim_dirty, accept;
  logic              ev_rd_hit, ev_wr_hit, ev_miss_alloc, ev_wr_around;
  logic              ev_evict_done, ev_fill_done, ev_word_done;

  assign look_addr     = (state_q == ST_IDLE) ? cpu_addr : rq_addr;
  assign lookup_hit    = rd_valid && (rd_tag == f_tag(look_addr));
  assign victim_dirty  = rd_valid && rd_dirty;
  assign accept        = (state_q == ST_IDLE) && cpu_req;
  assign ev_rd_hit     = accept && !cpu_we && lookup_hit;
  assign ev_wr_hit     = accept && cpu_we && lookup_hit;
  assign ev_miss_alloc = accept && !lookup_hit && (!cpu_we || cfg_write_alloc);
  assign ev_wr_around  = accept && cpu_we && !lookup_hit && !cfg_write_alloc;
  assign ev_evict_done = (state_q == ST_EVICT) && mem_ack;
  assign ev_fill_done  = (state_q == ST_FILL) && mem_ack;
  assign ev_word_done  = (state_q == ST_WORD) && mem_ack;

  dc_line_store #(.SETS(SETS), .TAG_W(TAG_W), .LINE_W(LINE_W)) u_store (
    .clk      (clk),
    .rst_n    (rst_n),
    .rd_idx   (f_idx(look_addr)),
    .rd_valid (rd_valid),
    .rd_dirty (rd_dirty),
    .rd_tag   (rd_tag),
    .rd_line  (rd_line),
    .wr_en    (wr_en),
    .wr_idx   (wr_idx),
    .wr_tag   (wr_tag),
    .wr_line  (wr_line),
    .wr_dirty (wr_dirty)
  );

  // ---- line update: store hit or refill install
  always_comb begin
    wr_en    = 1'b0;
    wr_idx   = f_idx(look_addr);
    wr_tag   = rd_tag;
    wr_line  = rd_line;
    wr_dirty = rd_dirty;
    if (ev_wr_hit) begin
      wr_en    = 1'b1;
      wr_line  = f_merge(rd_line, f_wsel(cpu_addr), cpu_wdata);
      wr_dirty = rd_dirty | cfg_write_back;
    end else if (ev_fill_done) begin
      wr_en    = 1'b1;
      wr_idx   = f_idx(rq_addr);
      wr_tag   = f_tag(rq_addr);
      wr_line  = rq_we ? f_merge(mem_rline, f_wsel(rq_addr), rq_wdata) : mem_rline;
      wr_dirty = rq_we && cfg_write_back;
    end
  end

  // ---- sequencing
  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE: begin
        if (ev_wr_hit && !cfg_write_back) state_d = ST_WORD;
        else if (ev_miss_alloc)           state_d = victim_dirty ? ST_EVICT : ST_FILL;
        else if (ev_wr_around)            state_d = ST_WORD;
      end
      ST_EVICT: if (mem_ack) state_d = ST_FILL;
      ST_FILL:  if (mem_ack) state_d = (rq_we && !cfg_write_back) ? ST_WORD : ST_IDLE;
      ST_WORD:  if (mem_ack) state_d = ST_IDLE;
      default:  state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= ST_IDLE;
      rq_we    <= 1'b0;
      rq_addr  <= '0;
      rq_wdata <= '0;
      ack_q    <= 1'b0;
      rdata_q  <= '0;
    end else begin
      state_q <= state_d;
      if (accept) begin
        rq_we    <= cpu_we;
        rq_addr  <= cpu_addr;
        rq_wdata <= cpu_wdata;
      end
      ack_q <= ev_rd_hit || (ev_wr_hit && cfg_write_back) || ev_word_done ||
               (ev_fill_done && !(rq_we && !cfg_write_back));
      if (ev_rd_hit)                  rdata_q <= f_pick(rd_line, f_wsel(cpu_addr));
      else if (ev_fill_done && !rq_we) rdata_q <= f_pick(mem_rline, f_wsel(rq_addr));
    end
  end

  assign cpu_ack   = ack_q;
  assign cpu_rdata = rdata_q;
  assign cpu_busy  = (state_q != ST_IDLE);

  dc_mem_port #(.ADDR_W(ADDR_W), .WORD_W(WORD_W), .LINE_W(LINE_W)) u_port (
    .state       (state_q),
    .victim_base (f_base(rd_tag, f_idx(rq_addr))),
    .fill_base   (f_base(f_tag(rq_addr), f_idx(rq_addr))),
    .word_addr   (f_waddr(rq_addr)),
    .victim_line (rd_line),
    .word_data   (rq_wdata),
    .mem_req     (mem_req),
    .mem_we      (mem_we),
    .mem_block   (mem_block),
    .mem_addr    (mem_addr),
    .mem_wline   (mem_wline),
    .mem_wword   (mem_wword)
  );

  // ---- assertions
  a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_block)));
  a_r10_busy: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> cpu_busy);
  a_r3_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_wr_hit && cfg_write_back) |=> (!mem_req && cpu_ack));
  a_r4_word: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_wr_hit && !cfg_write_back) |=> (mem_req && mem_we && !mem_block));
  a_r6_untouched: assert property (@(posedge clk) disable iff (!rst_n)
    ev_wr_around |-> !wr_en);
  a_r6_word: assert property (@(posedge clk) disable iff (!rst_n)
    ev_wr_around |=> (mem_req && mem_we && !mem_block));
  a_r7_first: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_miss_alloc && victim_dirty) |=> (mem_req && mem_we && mem_block));
  a_r7_then_fill: assert property (@(posedge clk) disable iff (!rst_n)
    ev_evict_done |=> (mem_req && !mem_we && mem_block));
  a_r8_no_wb: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_miss_alloc && !victim_dirty) |=> (mem_req && !mem_we));
endmodule

// File: tb/tb_dcache_policy_ctrl.sv
`timescale 1ns/1ps
module tb_dcache_policy_ctrl;
  localparam int AW = 16;
  localparam int WW = 64;
  localparam int LWD = 8;
  localparam int NS = 4;
  localparam int LW = WW * LWD;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cfg_wb = 1'b1, cfg_al = 1'b1;
  logic          cpu_req = 1'b0, cpu_we = 1'b0;
  logic [AW-1:0] cpu_addr = '0;
  logic [WW-1:0] cpu_wdata = '0;
  logic [WW-1:0] cpu_rdata;
  logic          cpu_ack, cpu_busy;
  logic          mem_req, mem_we, mem_block;
  logic [AW-1:0] mem_addr;
  logic [WW-1:0] mem_wword;
  logic [LW-1:0] mem_wline;
  logic [LW-1:0] mem_rline = '0;
  logic          mem_ack = 1'b0;

  always #4 clk = ~clk;

  dcache_policy_ctrl #(.ADDR_W(AW), .WORD_W(WW), .LINE_WORDS(LWD), .SETS(NS)) dut (
    .clk(clk), .rst_n(rst_n), .cfg_write_back(cfg_wb), .cfg_write_alloc(cfg_al),
    .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
    .cpu_rdata(cpu_rdata), .cpu_ack(cpu_ack), .cpu_busy(cpu_busy),
    .mem_req(mem_req), .mem_we(mem_we), .mem_block(mem_block), .mem_addr(mem_addr),
    .mem_wword(mem_wword), .mem_wline(mem_wline), .mem_rline(mem_rline), .mem_ack(mem_ack));

  int checks = 0, errors = 0;
  logic [63:0] bmem [int];
  logic [63:0] gold [int];

  function automatic logic [63:0] pat(int w);
    return (64'(w) * 64'h9E3779B97F4A7C15) ^ 64'h0123_4567_89AB_CDEF;
  endfunction
  function automatic logic [63:0] mem_rd(int w);
    return bmem.exists(w) ? bmem[w] : pat(w);
  endfunction
  function automatic logic [63:0] gold_rd(int w);
    return gold.exists(w) ? gold[w] : mem_rd(w);
  endfunction

  task automatic chk(bit ok, string rq, string what, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", rq, what, act, exp);
    end
  endtask

  // ---- next-level memory model: acknowledges on the second falling edge
  int n_ev = 0, n_fl = 0, n_wd = 0;
  logic [AW-1:0] ev_addr = '0, fl_addr = '0, wd_addr = '0;
  initial begin
    int lat;
    lat = 0;
    forever begin
      @(negedge clk);
      if (mem_ack) begin
        mem_ack = 1'b0;
        lat = 0;
      end else if (mem_req && rst_n) begin
        lat++;
        if (lat == 2) begin
          if (mem_we && mem_block) begin
            for (int i = 0; i < LWD; i++) bmem[int'(mem_addr >> 3) + i] = mem_wline[i*WW +: WW];
            n_ev++; ev_addr = mem_addr;
          end else if (mem_we) begin
            bmem[int'(mem_addr >> 3)] = mem_wword;
            n_wd++; wd_addr = mem_addr;
          end else begin
            for (int i = 0; i < LWD; i++) mem_rline[i*WW +: WW] = mem_rd(int'(mem_addr >> 3) + i);
            n_fl++; fl_addr = mem_addr;
          end
          mem_ack = 1'b1;
        end
      end
    end
  end

  // ---- bench view of line state
  bit       mv [NS];
  bit       md [NS];
  logic [7:0] mt [NS];

  task automatic do_reset();
    cpu_req = 1'b0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    for (int s = 0; s < NS; s++) begin mv[s] = 0; md[s] = 0; mt[s] = '0; end
    gold.delete();
    chk(cpu_busy == 1'b0, "R1", "busy after reset", 64'(cpu_busy), 64'd0);
    chk(mem_req == 1'b0, "R1", "mem_req after reset", 64'(mem_req), 64'd0);
    chk(cpu_ack == 1'b0, "R1", "ack after reset", 64'(cpu_ack), 64'd0);
  endtask

  task automatic run_op(bit we, logic [AW-1:0] a, logic [63:0] d);
    logic [1:0] idx;
    logic [7:0] tag;
    int w, cyc, e_ev, e_fl, e_wd, b_ev, b_fl, b_wd;
    bit hit, apath, busy1, quick;
    logic [AW-1:0] vbase;
    string rq;
    idx = a[7:6]; tag = a[15:8]; w = int'(a >> 3);
    hit   = mv[idx] && (mt[idx] == tag);
    apath = !hit && (!we || cfg_al);
    quick = hit && (!we || cfg_wb);
    vbase = {mt[idx], idx, 6'b0};
    e_ev  = (apath && mv[idx] && md[idx]) ? 1 : 0;
    e_fl  = apath ? 1 : 0;
    e_wd  = (we && (!cfg_wb || (!hit && !cfg_al))) ? 1 : 0;
    if (hit) rq = we ? (cfg_wb ? "R3" : "R4") : "R2";
    else if (apath) rq = (e_ev == 1) ? "R7" : (we ? "R5" : "R8");
    else rq = "R6";
    if (!we && !hit && !apath) rq = "R9";
    b_ev = n_ev; b_fl = n_fl; b_wd = n_wd;

    cpu_req = 1'b1; cpu_we = we; cpu_addr = a; cpu_wdata = d;
    @(posedge clk);
    @(negedge clk);
    cpu_req = 1'b0;
    cyc = 1;
    busy1 = cpu_busy;
    while (!cpu_ack && cyc < 400) begin
      @(negedge clk);
      cyc++;
    end

    chk(cpu_ack == 1'b1, rq, "ack seen", 64'(cpu_ack), 64'd1);
    if (quick) chk(cyc == 1, rq, "hit latency", 64'(cyc), 64'd1);
    else chk(busy1 == 1'b1, "R10", "busy during memory access", 64'(busy1), 64'd1);
    chk(n_ev - b_ev == e_ev, rq, "victim write-backs", 64'(n_ev - b_ev), 64'(e_ev));
    chk(n_fl - b_fl == e_fl, rq, "refills", 64'(n_fl - b_fl), 64'(e_fl));
    chk(n_wd - b_wd == e_wd, rq, "word writes", 64'(n_wd - b_wd), 64'(e_wd));
    if (e_ev == 1) begin
      chk(ev_addr == vbase, "R7", "victim base address", 64'(ev_addr), 64'(vbase));
      for (int i = 0; i < LWD; i++)
        chk(mem_rd(int'(vbase >> 3) + i) == gold_rd(int'(vbase >> 3) + i), "R7",
            "victim data in memory", mem_rd(int'(vbase >> 3) + i), gold_rd(int'(vbase >> 3) + i));
    end
    if (e_fl == 1)
      chk(fl_addr == {a[15:6], 6'b0}, "R11", "refill base address", 64'(fl_addr), 64'({a[15:6], 6'b0}));
    if (!we)
      chk(cpu_rdata == gold_rd(w), hit ? "R2" : "R9", "load data", cpu_rdata, gold_rd(w));
    if (we) begin
      gold[w] = d;
      if (e_wd == 1) begin
        chk(wd_addr == {a[15:3], 3'b0}, "R11", "word write address", 64'(wd_addr), 64'({a[15:3], 3'b0}));
        chk(mem_rd(w) == d, rq, "word write data", mem_rd(w), d);
      end
    end
    if (hit && we && cfg_wb) md[idx] = 1;
    if (apath) begin
      mv[idx] = 1; mt[idx] = tag; md[idx] = we && cfg_wb;
    end
  endtask

  // ---- watchdog
  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL R10 watchdog actual=running expected=finished");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [15:0] r;
    r = 16'hACE1;
    @(negedge clk);
    for (int m = 0; m < 4; m++) begin
      cfg_wb = (m == 0 || m == 2);
      cfg_al = (m < 2);
      do_reset();
      // store miss, store hit, then load of a conflicting block in the same set
      run_op(1'b1, 16'h0540, 64'h0000_0000_0000_FACE);
      run_op(1'b1, 16'h0545, 64'h0000_0000_0000_FEED);
      run_op(1'b0, 16'h0640, 64'h0);
      run_op(1'b0, 16'h0540, 64'h0);
      for (int k = 0; k < 150; k++) begin
        r = {r[14:0], r[15] ^ r[13] ^ r[12] ^ r[10]};
        run_op(r[0], {6'b0, r[2:1], r[4:3], r[7:5], r[10:8]},
               {r, ~r, r ^ 16'h5A5A, 16'(k)});
      end
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule